// File: doc/BRIEF.md
# Pipelined Multi-Channel SPI ADC Model

This block is a synthesizable SPI slave that acts like a multi-channel sampling ADC whose results come back through a two-frame pipeline. It is the target a scan sequencer talks to in simulation or on an FPGA prototype. Each 16-bit frame from the master carries a command word. When the frame closes, the block takes a sample of the chosen channel from a parallel input bus that holds one value per channel. That sample is held through the next frame, standing in for the conversion time. It is then shifted out on MISO during the frame after that.

The command word sets a mode flag, a range flag and the channel number, and a write-enable bit decides whether a frame changes any of them. Each result word carries the channel number in its top nibble and the sample left-justified below it. The channel count and the resolution are parameters. The SPI pins are sampled by the system clock, so each SCLK phase must last at least two clock cycles.

Top module: `adc_spi_model`

## Requirements
- R1: After reset, miso, manual_mode and range_x2 are 0 and the stored channel is 0.
- R2: A frame ends when cs_n rises. It is accepted only if exactly 16 rising SCLK edges occurred while cs_n was low. A frame with any other edge count changes no setting and does not advance the pipeline.
- R3: MOSI is sampled on rising SCLK edges, MSB first. MISO shows bit 15 of the result after cs_n falls, moves to the next lower bit after each falling SCLK edge, and is 0 while cs_n is high.
- R4: In an accepted frame with bit 11 (write) set, bit 12 is stored as manual_mode and bit 6 is stored as range_x2. If bit 12 is also set, bits 10:7 become the stored channel.
- R5: In an accepted frame with bit 11 clear, no setting changes, and the sample is taken from the stored channel.
- R6: A channel number in bits 10:7 that is NUM_CH or larger is ignored, and the stored channel is kept.
- R7: An accepted frame samples the selected channel of sample_bus in the clock cycle in which it ends. That result is shifted out during the second accepted frame after it. Changes on sample_bus after that cycle do not alter the result.
- R8: A result word holds the channel number in bits 15:12 and the sample in bits 11:(12-RES_BITS). Any bits below the sample are 0.
- R9: The first two accepted frames after reset return an all-zero word.
- R10: manual_mode and range_x2 show the stored settings by the second clock edge after cs_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Command data from the master |
| sample_bus | input | NUM_CH*RES_BITS | Sample values, channel k in bits k*RES_BITS upward |
| miso | output | 1 | Result data to the master |
| manual_mode | output | 1 | Stored mode flag |
| range_x2 | output | 1 | Stored double-range flag |

## Verification
The channel walk gives every channel its own sample value, so a mis-selected slice or a wrong channel field shows up in the result. Checking each result exactly two frames later also separates the correct pipeline depth from a depth of one or three. Frames with the write bit clear, with an out-of-range channel, and with manual mode cleared reveal whether the stored channel is held or wrongly replaced. Frames of 10 and 20 edges show whether a bad frame touched the settings or advanced the pipeline. Changing a sample after its frame has closed shows that the value was captured at the close of the frame.

// File: rtl/adc_spi_model_pkg.sv
package adc_spi_model_pkg;
  localparam int FRAME_LEN = 16;
  localparam int CH_FIELD_W = 4;
  localparam int DATA_FIELD_W = 12;

  typedef struct packed {
    logic       manual;
    logic       write;
    logic [3:0] chan;
    logic       range_x2;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [FRAME_LEN-1:0] w);
    cmd_t c;
    c.manual   = w[12];
    c.write    = w[11];
    c.chan     = w[10:7];
    c.range_x2 = w[6];
    return c;
  endfunction
endpackage

// File: rtl/adc_spi_frame_rx.sv
module adc_spi_frame_rx #(
  parameter int FRAME_LEN = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 mosi,
  output logic                 frame_start,
  output logic                 sclk_fall,
  output logic                 frame_ok,
  output logic [FRAME_LEN-1:0] cmd_word
);
  localparam int CNT_W = $clog2(FRAME_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_LEN + 1);

  logic             sclk_q, cs_q;
  logic             sclk_rise, frame_end;
  logic [CNT_W-1:0] edge_cnt;
  logic [FRAME_LEN-1:0] rx_sh;

  assign sclk_rise   = sclk & ~sclk_q & ~cs_n;
  assign sclk_fall   = ~sclk & sclk_q & ~cs_n;
  assign frame_start = cs_q & ~cs_n;
  assign frame_end   = ~cs_q & cs_n;
  assign frame_ok    = frame_end && (edge_cnt == CNT_W'(FRAME_LEN));
  assign cmd_word    = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      edge_cnt <= '0;
      rx_sh    <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (frame_start) begin
        edge_cnt <= '0;
      end else if (sclk_rise) begin
        rx_sh <= {rx_sh[FRAME_LEN-2:0], mosi};
        if (edge_cnt != CNT_SAT) edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_spi_cmd_decode.sv
module adc_spi_cmd_decode
  import adc_spi_model_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_ok,
  input  logic [FRAME_LEN-1:0] cmd_word,
  output logic [3:0]           sample_ch,
  output logic                 manual_mode,
  output logic                 range_x2
);
  cmd_t       cmd;
  logic [3:0] ch_q, ch_nxt;

  always_comb begin
    cmd    = decode_cmd(cmd_word);
    ch_nxt = ch_q;
    if (cmd.write && cmd.manual && (int'(cmd.chan) < NUM_CH)) ch_nxt = cmd.chan;
  end

  assign sample_ch = ch_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_q        <= '0;
      manual_mode <= 1'b0;
      range_x2    <= 1'b0;
    end else if (frame_ok) begin
      ch_q <= ch_nxt;
      if (cmd.write) begin
        manual_mode <= cmd.manual;
        range_x2    <= cmd.range_x2;
      end
    end
  end
endmodule

// File: rtl/adc_spi_conv_pipe.sv
module adc_spi_conv_pipe
  import adc_spi_model_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int RES_BITS = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         frame_ok,
  input  logic [3:0]                   sample_ch,
  input  logic [NUM_CH*RES_BITS-1:0]   sample_bus,
  output logic [FRAME_LEN-1:0]         out_word
);
  localparam int PAD_W = DATA_FIELD_W - RES_BITS;

  logic [RES_BITS-1:0]     smp;
  logic [DATA_FIELD_W-1:0] field;
  logic [FRAME_LEN-1:0]    conv_q;

  assign smp = sample_bus[int'(sample_ch)*RES_BITS +: RES_BITS];

  generate
    if (PAD_W == 0) begin : g_full
      assign field = smp;
    end else begin : g_pad
      assign field = {smp, {PAD_W{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_q   <= '0;
      out_word <= '0;
    end else if (frame_ok) begin
      conv_q   <= {sample_ch, field};
      out_word <= conv_q;
    end
  end
endmodule

// File: rtl/adc_spi_tx.sv
module adc_spi_tx #(
  parameter int FRAME_LEN = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 frame_start,
  input  logic                 sclk_fall,
  input  logic [FRAME_LEN-1:0] load_word,
  output logic                 miso
);
  logic [FRAME_LEN-1:0] tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
      miso  <= 1'b0;
    end else if (frame_start) begin
      miso  <= load_word[FRAME_LEN-1];
      tx_sh <= {load_word[FRAME_LEN-2:0], 1'b0};
    end else if (cs_n) begin
      miso <= 1'b0;
    end else if (sclk_fall) begin
      miso  <= tx_sh[FRAME_LEN-1];
      tx_sh <= {tx_sh[FRAME_LEN-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/adc_spi_model.sv
module adc_spi_model
  import adc_spi_model_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int RES_BITS = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sclk,
  input  logic                       cs_n,
  input  logic                       mosi,
  input  logic [NUM_CH*RES_BITS-1:0] sample_bus,
  output logic                       miso,
  output logic                       manual_mode,
  output logic                       range_x2
);
  logic                 frame_start, sclk_fall, frame_ok;
  logic [FRAME_LEN-1:0] cmd_word, out_word;
  logic [3:0]           sample_ch;

  adc_spi_frame_rx #(.FRAME_LEN(FRAME_LEN)) u_rx (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .frame_start(frame_start), .sclk_fall(sclk_fall),
    .frame_ok(frame_ok), .cmd_word(cmd_word)
  );

  adc_spi_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .clk(clk), .rst(rst), .frame_ok(frame_ok), .cmd_word(cmd_word),
    .sample_ch(sample_ch), .manual_mode(manual_mode), .range_x2(range_x2)
  );

  adc_spi_conv_pipe #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_pipe (
    .clk(clk), .rst(rst), .frame_ok(frame_ok), .sample_ch(sample_ch),
    .sample_bus(sample_bus), .out_word(out_word)
  );

  adc_spi_tx #(.FRAME_LEN(FRAME_LEN)) u_tx (
    .clk(clk), .rst(rst), .cs_n(cs_n), .frame_start(frame_start),
    .sclk_fall(sclk_fall), .load_word(out_word), .miso(miso)
  );
endmodule

// File: rtl/adc_spi_model_chk.sv
module adc_spi_model_chk #(
  parameter int NUM_CH   = 8,
  parameter int RES_BITS = 12
) (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        miso,
  input logic        frame_ok,
  input logic [3:0]  sample_ch,
  input logic [15:0] out_word,
  input logic        manual_mode,
  input logic        range_x2
);
  localparam logic [15:0] LOW_MASK = 16'((1 << (12 - RES_BITS)) - 1);

  // R3
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !miso);

  // R2
  range_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_ok |=> $stable(range_x2));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_ok |=> $stable(manual_mode));

  // R6
  ch_bound_chk: assert property (@(posedge clk) disable iff (rst)
    frame_ok |-> (int'(sample_ch) < NUM_CH));

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_ok |=> $stable(out_word));

  // R8
  low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_word & LOW_MASK) == 16'h0000);

  // R8
  word_ch_chk: assert property (@(posedge clk) disable iff (rst)
    int'(out_word[15:12]) < NUM_CH);
endmodule

bind adc_spi_model adc_spi_model_chk #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .miso(miso), .frame_ok(frame_ok),
  .sample_ch(sample_ch), .out_word(out_word),
  .manual_mode(manual_mode), .range_x2(range_x2)
);

// File: tb/adc_spi_model_test.sv
module adc_spi_model_test;
  localparam int NUM_CH = 8;
  localparam int RES = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic [NUM_CH*RES-1:0] sample_bus;
  logic miso, manual_mode, range_x2;
  logic [11:0] smp [16];

  int n_chk = 0;
  int n_err = 0;

  logic [15:0] m_out, m_conv;
  logic [3:0]  m_ch;
  logic        m_man, m_rng;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) sample_bus[i*RES +: RES] = smp[i][RES-1:0];
  end

  adc_spi_model #(.NUM_CH(NUM_CH), .RES_BITS(RES)) uut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sample_bus(sample_bus), .miso(miso),
    .manual_mode(manual_mode), .range_x2(range_x2)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] fmt(input logic [3:0] ch, input logic [11:0] v);
    logic [11:0] f;
    f = 12'(v & 12'((1 << RES) - 1)) << (12 - RES);
    return {ch, f};
  endfunction

  function automatic logic [15:0] wcmd(input logic man, input int ch, input logic rng);
    return {3'b000, man, 1'b1, 4'(ch), rng, 6'b0};
  endfunction

  task automatic model_frame(input logic [15:0] c);
    logic [3:0] nxt;
    nxt = m_ch;
    if (c[11] && c[12] && int'(c[10:7]) < NUM_CH) nxt = c[10:7];
    m_out  = m_conv;
    m_conv = fmt(nxt, smp[nxt]);
    m_ch   = nxt;
    if (c[11]) begin
      m_man = c[12];
      m_rng = c[6];
    end
  endtask

  task automatic xfer(input logic [15:0] c, input int nbits, output logic [15:0] got);
    got = '0;
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      repeat (4) @(negedge clk);
      mosi = (i < 16) ? c[15-i] : 1'b0;
      if (i < 16) got[15-i] = miso;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic frame_chk(input logic [15:0] c, input string tag);
    logic [15:0] got, exp;
    exp = m_out;
    xfer(c, 16, got);
    chk(tag, got, exp);
    model_frame(c);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    m_out = '0; m_conv = '0; m_ch = '0; m_man = 1'b0; m_rng = 1'b0;
    chk("R1 miso after reset", {15'b0, miso}, 16'h0);
    chk("R1 manual_mode after reset", {15'b0, manual_mode}, 16'h0);
    chk("R1 range_x2 after reset", {15'b0, range_x2}, 16'h0);
  endtask

  task automatic t_fill;
    frame_chk(wcmd(1'b1, 3, 1'b0), "R9 first frame zero");
    frame_chk(wcmd(1'b1, 5, 1'b0), "R9 second frame zero");
    frame_chk(wcmd(1'b1, 1, 1'b0), "R7 third frame carries ch3");
    chk("R10 manual_mode set", {15'b0, manual_mode}, {15'b0, m_man});
  endtask

  task automatic t_walk;
    for (int k = 0; k < NUM_CH; k++) frame_chk(wcmd(1'b1, k, 1'b0), "R8 channel walk");
    frame_chk(wcmd(1'b1, 0, 1'b0), "R7 walk flush a");
    frame_chk(wcmd(1'b1, 0, 1'b0), "R7 walk flush b");
  endtask

  task automatic t_nowrite;
    frame_chk(wcmd(1'b1, 6, 1'b1), "R4 set ch6");
    chk("R10 range set", {15'b0, range_x2}, 16'h1);
    frame_chk(16'h1000 | (16'(2) << 7), "R5 no-write frame a");
    chk("R5 range kept", {15'b0, range_x2}, 16'h1);
    frame_chk(16'h1000 | (16'(4) << 7), "R5 no-write frame b");
    frame_chk(16'h1000, "R5 stored channel sampled a");
    frame_chk(16'h1000, "R5 stored channel sampled b");
  endtask

  task automatic t_range_mode;
    frame_chk(wcmd(1'b1, 2, 1'b0), "R4 range clear frame");
    chk("R4 range cleared", {15'b0, range_x2}, 16'h0);
    frame_chk(wcmd(1'b0, 7, 1'b1), "R4 auto-mode write");
    chk("R4 manual cleared", {15'b0, manual_mode}, 16'h0);
    chk("R4 range set with mode clear", {15'b0, range_x2}, 16'h1);
    frame_chk(16'h0000, "R4 channel kept in auto a");
    frame_chk(16'h0000, "R4 channel kept in auto b");
  endtask

  task automatic t_badch;
    frame_chk(wcmd(1'b1, 5, 1'b0), "R6 set ch5");
    frame_chk(wcmd(1'b1, 12, 1'b0), "R6 out-of-range channel");
    frame_chk(wcmd(1'b1, 15, 1'b0), "R6 result of ch5");
    frame_chk(wcmd(1'b1, 1, 1'b0), "R6 out-of-range kept ch5");
  endtask

  task automatic t_short;
    logic [15:0] dummy;
    frame_chk(wcmd(1'b1, 4, 1'b0), "R2 baseline a");
    frame_chk(wcmd(1'b1, 7, 1'b0), "R2 baseline b");
    xfer(wcmd(1'b1, 2, 1'b1), 10, dummy);
    chk("R2 short frame keeps range", {15'b0, range_x2}, 16'h0);
    xfer(wcmd(1'b1, 3, 1'b1), 20, dummy);
    chk("R2 long frame keeps range", {15'b0, range_x2}, 16'h0);
    frame_chk(wcmd(1'b1, 6, 1'b0), "R2 pipeline not advanced a");
    frame_chk(wcmd(1'b1, 6, 1'b0), "R2 pipeline not advanced b");
  endtask

  task automatic t_hold;
    smp[2] = 12'hA5C;
    frame_chk(wcmd(1'b1, 2, 1'b0), "R7 capture frame");
    smp[2] = 12'h123;
    chk("R3 miso idle between frames", {15'b0, miso}, 16'h0);
    frame_chk(wcmd(1'b1, 0, 1'b0), "R7 conversion frame");
    frame_chk(wcmd(1'b1, 0, 1'b0), "R7 captured value kept");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) smp[i] = 12'(12'h111 * (i + 1) ^ 12'h8C3);
    t_reset();
    t_fill();
    t_walk();
    t_nowrite();
    t_range_mode();
    t_badch();
    t_short();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule